// File: doc/BRIEF.md
# Accumulator Arithmetic Unit with Decimal Adjust

This block is the arithmetic core of an 8-bit accumulator machine. It takes the accumulator value, a second operand (the B register or a fetched byte), the carry and auxiliary-carry flags, and a 3-bit operation code. It returns a new accumulator, a new B value, and the carry (CY), auxiliary carry (AC) and overflow (OV) flags. The operations are add, add with carry, subtract with borrow, unsigned multiply, unsigned divide and a BCD decimal adjust of the accumulator.

Each operation starts with a one-cycle `start_i` pulse and ends with a one-cycle `done_o` pulse. The add, subtract and decimal-adjust operations finish after one clock. Multiply and divide run one bit per clock in shared shift registers, and `busy_o` is high while they run. The result registers keep their values between completions, so the sequencer around the block can read them at any time after `done_o`.

Top module: `acc_alu`

## Requirements
- R1: While `rst_ni` is low and after its release, `a_o`, `b_o`, `cy_o`, `ac_o`, `ov_o`, `busy_o` and `done_o` are all 0.
- R2: Op 0 (add) gives `a_o` = (a_i + b_i) mod 256. Op 1 (add with carry) gives (a_i + b_i + cy_i) mod 256. For both, CY is the carry out of bit 7, AC is the carry out of bit 3, OV is the two's-complement overflow, and `b_o` = b_i.
- R3: Op 2 (subtract with borrow) gives `a_o` = (a_i − b_i − cy_i) mod 256. CY is set when bit 7 needs a borrow, AC is set when bit 3 needs a borrow, OV is the two's-complement overflow, and `b_o` = b_i.
- R4: Op 3 (multiply) forms the unsigned 16-bit product of a_i and b_i, with the low byte on `a_o` and the high byte on `b_o`. CY is 0, OV is 1 exactly when the product exceeds 255, and AC equals ac_i. For example, 45h × F5h gives a_o = 09h and b_o = 42h.
- R5: Op 4 (divide) with b_i ≠ 0 gives the unsigned quotient on `a_o` and the remainder on `b_o`. CY is 0, OV is 0 and AC equals ac_i.
- R6: Op 4 with b_i = 0 sets OV to 1 and CY to 0. `a_o` and `b_o` are unspecified.
- R7: Op 5 (decimal adjust) first adds 06h when the low nibble of a_i is above 9 or ac_i is 1. It then adds 60h when the high nibble is above 9, when cy_i is 1, or when the first step carried out. CY is set by cy_i or by any carry out, and is never cleared. AC equals ac_i, OV is 0 and `b_o` = b_i. ABh gives 11h with CY = 1, and 78h stays 78h with flags 0.
- R8: For ops 0, 1, 2, 5, 6 and 7, `done_o` pulses in the cycle after the clock edge that accepts `start_i`. For ops 3 and 4, `busy_o` is high from that edge, and `done_o` pulses 9 cycles after it (data width + 1), in the same edge where `busy_o` falls. `busy_o` and `done_o` are never high together.
- R9: `start_i` is ignored while `busy_o` is high. `a_o`, `b_o` and the flags change only in a cycle where `done_o` is high.
- R10: Codes 6 and 7 are reserved. They produce a `done_o` pulse and leave `a_o`, `b_o` and all flags unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, accepted when not busy |
| op_i | input | 3 | Operation code (see R10) |
| a_i | input | 8 | Accumulator operand |
| b_i | input | 8 | Second operand / B register |
| cy_i | input | 1 | Carry flag in |
| ac_i | input | 1 | Auxiliary carry flag in |
| a_o | output | 8 | New accumulator |
| b_o | output | 8 | New B value |
| cy_o | output | 1 | Carry flag out |
| ac_o | output | 1 | Auxiliary carry flag out |
| ov_o | output | 1 | Overflow flag out |
| busy_o | output | 1 | Multiply or divide in progress |
| done_o | output | 1 | Result valid pulse |

## Verification
The bench targets the following corner cases, each listed with how a faulty design would show it:
- Subtraction across zero with a borrow in. A design that inverts the borrow sense reports CY and AC backwards.
- Signed overflow at 7Fh/80h. A design that takes OV from the wrong carry marks overflow on ordinary unsigned wraps.
- Decimal adjust with the low-step carry, the AC-only and CY-only cases, and CY set on entry. A design that drops CY on entry turns a three-digit BCD sum into a two-digit one.
- Multiply at the 255 boundary, and divide by a larger divisor, by 1 and by 0. A wrong step count or a bad restore shows up as a shifted product or quotient.
- Start pulses held high during a multiply. A design that restarts would stretch `busy_o` and return the wrong result.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_ADDC = 3'd1,
    OP_SUBB = 3'd2,
    OP_MUL  = 3'd3,
    OP_DIV  = 3'd4,
    OP_DADJ = 3'd5,
    OP_RSV6 = 3'd6,
    OP_RSV7 = 3'd7
  } alu_op_e;

  typedef struct packed {
    logic cy;
    logic ac;
    logic ov;
  } alu_flags_t;

endpackage

// File: rtl/acc_alu_addsub.sv
module acc_alu_addsub #(
  parameter int unsigned W = 8
) (
  input  logic                    sub_i,
  input  logic                    use_cy_i,
  input  logic [W-1:0]            a_i,
  input  logic [W-1:0]            b_i,
  input  logic                    cy_i,
  output logic [W-1:0]            res_o,
  output acc_alu_pkg::alu_flags_t flags_o
);
  localparam int unsigned H = W / 2;

  logic [W-1:0] b_eff;
  logic         cin;
  logic [H:0]   lo_sum;
  logic [W-1:0] mid_sum;
  logic [W:0]   full_sum;

  // Subtraction as a + ~b + ~borrow; carries come out inverted.
  always_comb begin
    b_eff    = sub_i ? ~b_i : b_i;
    cin      = sub_i ? ~(use_cy_i & cy_i) : (use_cy_i & cy_i);
    lo_sum   = {1'b0, a_i[H-1:0]} + {1'b0, b_eff[H-1:0]} + {{H{1'b0}}, cin};
    mid_sum  = {1'b0, a_i[W-2:0]} + {1'b0, b_eff[W-2:0]} + {{(W-1){1'b0}}, cin};
    full_sum = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, cin};
    res_o      = full_sum[W-1:0];
    flags_o.cy = full_sum[W] ^ sub_i;
    flags_o.ac = lo_sum[H] ^ sub_i;
    flags_o.ov = full_sum[W] ^ mid_sum[W-1];
  end

endmodule

// File: rtl/acc_alu_dadj.sv
module acc_alu_dadj #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic         cy_i,
  input  logic         ac_i,
  output logic [W-1:0] res_o,
  output logic         cy_o
);
  logic [W:0] step1;
  logic [W:0] step2;
  logic       c1;
  logic       fix_hi;

  always_comb begin
    step1 = {1'b0, a_i};
    if (a_i[3:0] > 4'd9 || ac_i) step1 = {1'b0, a_i} + (W+1)'(6);
    c1     = step1[W];
    fix_hi = (step1[W-1:4] > (W-4)'(9)) || cy_i || c1;
    step2  = {1'b0, step1[W-1:0]};
    if (fix_hi) step2 = {1'b0, step1[W-1:0]} + (W+1)'(8'h60);
    res_o = step2[W-1:0];
    cy_o  = cy_i | c1 | step2[W];
  end

endmodule

// File: rtl/acc_alu_mul.sv
module acc_alu_mul #(
  parameter int unsigned W = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  output logic           done_o,
  output logic [2*W-1:0] prod_o
);
  localparam int unsigned CW = $clog2(W + 1);

  logic [CW-1:0]  cnt_q;
  logic [W-1:0]   mc_q;
  logic [2*W-1:0] p_q;
  logic [W:0]     sum;
  logic [2*W-1:0] p_nxt;

  always_comb begin
    sum   = {1'b0, p_q[2*W-1:W]} + (p_q[0] ? {1'b0, mc_q} : '0);
    p_nxt = {sum, p_q[W-1:1]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      mc_q   <= '0;
      p_q    <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_i) begin
        p_q   <= {{W{1'b0}}, b_i};
        mc_q  <= a_i;
        cnt_q <= CW'(W);
      end else if (cnt_q != '0) begin
        p_q   <= p_nxt;
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) done_o <= 1'b1;
      end
    end
  end

  assign prod_o = p_q;

  AST_MUL_DONE_AT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> cnt_q == '0); // R8

endmodule

// File: rtl/acc_alu_div.sv
module acc_alu_div #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] num_i,
  input  logic [W-1:0] den_i,
  output logic         done_o,
  output logic [W-1:0] quo_o,
  output logic [W-1:0] rem_o,
  output logic         dz_o
);
  localparam int unsigned CW = $clog2(W + 1);

  logic [CW-1:0] cnt_q;
  logic [W-1:0]  q_q;
  logic [W-1:0]  r_q;
  logic [W-1:0]  d_q;
  logic [W:0]    shifted;
  logic [W:0]    diff;

  always_comb begin
    shifted = {r_q, q_q[W-1]};
    diff    = shifted - {1'b0, d_q};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      q_q    <= '0;
      r_q    <= '0;
      d_q    <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_i) begin
        q_q   <= num_i;
        r_q   <= '0;
        d_q   <= den_i;
        cnt_q <= CW'(W);
      end else if (cnt_q != '0) begin
        if (!diff[W]) begin
          r_q <= diff[W-1:0];
          q_q <= {q_q[W-2:0], 1'b1};
        end else begin
          r_q <= shifted[W-1:0];
          q_q <= {q_q[W-2:0], 1'b0};
        end
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) done_o <= 1'b1;
      end
    end
  end

  assign quo_o = q_q;
  assign rem_o = r_q;
  assign dz_o  = (d_q == '0);

  AST_DIV_REM_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0 && d_q != '0) |-> r_q < d_q); // R5

endmodule

// File: rtl/acc_alu.sv
module acc_alu #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [2:0]    op_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          cy_i,
  input  logic          ac_i,
  output logic [DW-1:0] a_o,
  output logic [DW-1:0] b_o,
  output logic          cy_o,
  output logic          ac_o,
  output logic          ov_o,
  output logic          busy_o,
  output logic          done_o
);
  import acc_alu_pkg::*;

  alu_op_e    op_w;
  alu_op_e    op_q;
  logic       busy_q;
  logic       done_q;
  logic       ac_keep_q;
  logic [DW-1:0] a_q;
  logic [DW-1:0] b_q;
  alu_flags_t    flags_q;

  logic          accept;
  logic          mul_go;
  logic          div_go;
  logic [DW-1:0] as_res;
  alu_flags_t    as_flags;
  logic [DW-1:0] da_res;
  logic          da_cy;
  logic          mul_done;
  logic [2*DW-1:0] prod;
  logic          div_done;
  logic [DW-1:0] quo;
  logic [DW-1:0] rem;
  logic          div_zero;

  assign op_w   = alu_op_e'(op_i);
  assign accept = start_i && !busy_q;
  assign mul_go = accept && (op_w == OP_MUL);
  assign div_go = accept && (op_w == OP_DIV);

  acc_alu_addsub #(.W(DW)) u_addsub (
    .sub_i   (op_w == OP_SUBB),
    .use_cy_i(op_w != OP_ADD),
    .a_i     (a_i),
    .b_i     (b_i),
    .cy_i    (cy_i),
    .res_o   (as_res),
    .flags_o (as_flags)
  );

  acc_alu_dadj #(.W(DW)) u_dadj (
    .a_i  (a_i),
    .cy_i (cy_i),
    .ac_i (ac_i),
    .res_o(da_res),
    .cy_o (da_cy)
  );

  acc_alu_mul #(.W(DW)) u_mul (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(mul_go),
    .a_i    (a_i),
    .b_i    (b_i),
    .done_o (mul_done),
    .prod_o (prod)
  );

  acc_alu_div #(.W(DW)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(div_go),
    .num_i  (a_i),
    .den_i  (b_i),
    .done_o (div_done),
    .quo_o  (quo),
    .rem_o  (rem),
    .dz_o   (div_zero)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q      <= OP_ADD;
      busy_q    <= 1'b0;
      done_q    <= 1'b0;
      ac_keep_q <= 1'b0;
      a_q       <= '0;
      b_q       <= '0;
      flags_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (busy_q) begin
        if (op_q == OP_MUL && mul_done) begin
          a_q     <= prod[DW-1:0];
          b_q     <= prod[2*DW-1:DW];
          flags_q <= '{cy: 1'b0, ac: ac_keep_q, ov: |prod[2*DW-1:DW]};
          busy_q  <= 1'b0;
          done_q  <= 1'b1;
        end else if (op_q == OP_DIV && div_done) begin
          a_q     <= quo;
          b_q     <= rem;
          flags_q <= '{cy: 1'b0, ac: ac_keep_q, ov: div_zero};
          busy_q  <= 1'b0;
          done_q  <= 1'b1;
        end
      end else if (start_i) begin
        op_q <= op_w;
        unique case (op_w)
          OP_ADD, OP_ADDC, OP_SUBB: begin
            a_q     <= as_res;
            b_q     <= b_i;
            flags_q <= as_flags;
            done_q  <= 1'b1;
          end
          OP_DADJ: begin
            a_q     <= da_res;
            b_q     <= b_i;
            flags_q <= '{cy: da_cy, ac: ac_i, ov: 1'b0};
            done_q  <= 1'b1;
          end
          OP_MUL, OP_DIV: begin
            ac_keep_q <= ac_i;
            busy_q    <= 1'b1;
          end
          default: done_q <= 1'b1;
        endcase
      end
    end
  end

  assign a_o    = a_q;
  assign b_o    = b_q;
  assign cy_o   = flags_q.cy;
  assign ac_o   = flags_q.ac;
  assign ov_o   = flags_q.ov;
  assign busy_o = busy_q;
  assign done_o = done_q;

  AST_BUSY_DONE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !done_o); // R8
  AST_BUSY_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> (busy_o || done_o)); // R9
  AST_RESULT_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(a_o) && $stable(b_o) && $stable(cy_o) && $stable(ov_o))); // R9
  AST_MUL_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && op_q == OP_MUL) |-> (!cy_o && (ov_o == (b_o != '0)))); // R4
  AST_DIV_NO_CY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && op_q == OP_DIV) |-> !cy_o); // R5
  AST_DADJ_KEEP_CY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && op_q == OP_DADJ && $past(cy_i)) |-> cy_o); // R7

endmodule

// File: tb/tb_acc_alu.sv
`timescale 1ns/1ps
module tb_acc_alu;
  localparam int DW = 8;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic [2:0]    op_i = '0;
  logic [DW-1:0] a_i = '0;
  logic [DW-1:0] b_i = '0;
  logic          cy_i = 1'b0;
  logic          ac_i = 1'b0;
  logic [DW-1:0] a_o;
  logic [DW-1:0] b_o;
  logic          cy_o, ac_o, ov_o, busy_o, done_o;

  int n_checks = 0;
  int n_fail   = 0;

  always #2 clk_i = ~clk_i;

  acc_alu #(.DW(DW)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .op_i(op_i),
    .a_i(a_i), .b_i(b_i), .cy_i(cy_i), .ac_i(ac_i),
    .a_o(a_o), .b_o(b_o), .cy_o(cy_o), .ac_o(ac_o), .ov_o(ov_o),
    .busy_o(busy_o), .done_o(done_o)
  );

  // Behavioural reference model, advanced on every rising edge.
  int m_a, m_b, m_cy, m_ac, m_ov, m_done, m_busy, m_cnt, m_mask;
  int p_a, p_b, p_cy, p_ac, p_ov, p_mask;
  string m_tag, p_tag;

  function automatic int sgn(int v);
    return (v >= 128) ? v - 256 : v;
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_a = 0; m_b = 0; m_cy = 0; m_ac = 0; m_ov = 0;
      m_done = 0; m_busy = 0; m_cnt = 0; m_mask = 0; m_tag = "R1";
    end else begin
      m_done = 0;
      if (m_busy != 0) begin
        m_cnt--;
        if (m_cnt == 0) begin
          m_busy = 0; m_done = 1;
          m_a = p_a; m_b = p_b; m_cy = p_cy; m_ac = p_ac; m_ov = p_ov;
          m_mask = p_mask; m_tag = p_tag;
        end
      end else if (start_i) begin
        int a, b, c, h, s, ss, v;
        a = int'(a_i); b = int'(b_i); c = int'(cy_i); h = int'(ac_i);
        case (op_i)
          3'd0, 3'd1: begin
            if (op_i == 3'd0) c = 0;
            s  = a + b + c;
            ss = sgn(a) + sgn(b) + c;
            m_a = s % 256; m_b = b; m_cy = (s > 255);
            m_ac = (((a % 16) + (b % 16) + c) > 15);
            m_ov = (ss > 127 || ss < -128);
            m_mask = 0; m_tag = "R2"; m_done = 1;
          end
          3'd2: begin
            s  = a - b - c;
            ss = sgn(a) - sgn(b) - c;
            m_a = (s + 512) % 256; m_b = b; m_cy = (s < 0);
            m_ac = (((a % 16) - (b % 16) - c) < 0);
            m_ov = (ss > 127 || ss < -128);
            m_mask = 0; m_tag = "R3"; m_done = 1;
          end
          3'd3: begin
            s = a * b;
            p_a = s % 256; p_b = s / 256; p_cy = 0; p_ac = h; p_ov = (s > 255);
            p_mask = 0; p_tag = "R4";
            m_busy = 1; m_cnt = DW + 1;
          end
          3'd4: begin
            p_cy = 0; p_ac = h;
            if (b == 0) begin
              p_a = 0; p_b = 0; p_ov = 1; p_mask = 1; p_tag = "R6";
            end else begin
              p_a = a / b; p_b = a % b; p_ov = 0; p_mask = 0; p_tag = "R5";
            end
            m_busy = 1; m_cnt = DW + 1;
          end
          3'd5: begin
            v = a;
            if ((v % 16) > 9 || h != 0) v = v + 6;
            if (v > 255) c = 1;
            if (((v / 16) % 16) > 9 || c != 0) v = v + 96;
            if (v > 255) c = 1;
            m_a = v % 256; m_b = b; m_cy = c; m_ac = h; m_ov = 0;
            m_mask = 0; m_tag = "R7"; m_done = 1;
          end
          default: begin
            m_done = 1; m_tag = "R10";
          end
        endcase
      end
    end
  end

  task automatic chk(string tag, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Compare on every falling edge, away from the active edge.
  always @(negedge clk_i) begin
    if (rst_ni) begin
      chk("R8 R9", "done", int'(done_o), m_done);
      chk("R8 R9", "busy", int'(busy_o), m_busy);
      chk(m_tag, "cy", int'(cy_o), m_cy);
      chk(m_tag, "ov", int'(ov_o), m_ov);
      chk(m_tag, "ac", int'(ac_o), m_ac);
      if (m_mask == 0) begin
        chk(m_tag, "a", int'(a_o), m_a);
        chk(m_tag, "b", int'(b_o), m_b);
      end
    end
  end

  task automatic run_op(int op, int a, int b, int c, int h);
    @(negedge clk_i);
    start_i = 1'b1; op_i = 3'(op); a_i = 8'(a); b_i = 8'(b);
    cy_i = 1'(c); ac_i = 1'(h);
    @(negedge clk_i);
    start_i = 1'b0;
    while (m_done == 0) @(negedge clk_i);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1: reset state
    chk("R1", "a", int'(a_o), 0); chk("R1", "b", int'(b_o), 0);
    chk("R1", "flags", int'({cy_o, ac_o, ov_o, busy_o, done_o}), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1", "after release", int'({a_o, b_o, cy_o, ac_o, ov_o, busy_o, done_o}), 0);

    // R2: add / add with carry, overflow and nibble carry
    run_op(0, 8'h23, 8'h55, 1, 0);
    run_op(0, 8'h7F, 8'h01, 0, 0);
    run_op(1, 8'hFF, 8'h00, 1, 0);
    run_op(1, 8'h80, 8'h80, 1, 0);
    // R3: subtract with borrow
    run_op(2, 8'h00, 8'h00, 1, 0);
    run_op(2, 8'h80, 8'h01, 0, 0);
    run_op(2, 8'h10, 8'h01, 0, 0);
    // R7: decimal adjust corner cases
    run_op(5, 8'hAB, 0, 0, 0);
    run_op(5, 8'h78, 0, 0, 0);
    run_op(5, 8'h12, 0, 0, 1);
    run_op(5, 8'h12, 0, 1, 0);
    run_op(5, 8'hFA, 0, 0, 0);
    run_op(5, 8'h9A, 0, 0, 0);
    // R4: multiply
    run_op(3, 8'h45, 8'hF5, 1, 1);
    run_op(3, 8'h0F, 8'h11, 0, 0);
    run_op(3, 8'h10, 8'h10, 0, 0);
    run_op(3, 8'hFF, 8'hFF, 0, 0);
    // R5 / R6: divide
    run_op(4, 8'hE8, 8'h1B, 1, 0);
    run_op(4, 8'h05, 8'h09, 0, 1);
    run_op(4, 8'hFF, 8'h01, 0, 0);
    run_op(4, 8'h42, 8'h00, 1, 0);
    // R10: reserved codes leave results unchanged
    run_op(3, 8'h12, 8'h34, 0, 1);
    run_op(6, 8'hAA, 8'hBB, 1, 0);
    run_op(7, 8'h55, 8'h66, 0, 0);

    // R9: starts held high during a multiply are ignored
    @(negedge clk_i);
    start_i = 1'b1; op_i = 3'd3; a_i = 8'hC3; b_i = 8'h5A; cy_i = 1'b0; ac_i = 1'b0;
    @(negedge clk_i);
    op_i = 3'd0; a_i = 8'h01; b_i = 8'h02;
    repeat (4) @(negedge clk_i);
    start_i = 1'b0;
    while (m_done == 0) @(negedge clk_i);
    // R8: back-to-back single-cycle starts
    @(negedge clk_i);
    start_i = 1'b1; op_i = 3'd0; a_i = 8'h11; b_i = 8'h22;
    @(negedge clk_i);
    op_i = 3'd2; a_i = 8'h05; b_i = 8'h07; cy_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    @(negedge clk_i);

    for (int i = 0; i < 400; i++) begin
      run_op(int'($urandom % 8), int'($urandom % 256), int'($urandom % 256),
             int'($urandom % 2), int'($urandom % 2));
    end
    repeat (3) @(negedge clk_i);
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule